// File: doc/BRIEF.md
# Sequential Karatsuba Binary-Polynomial Multiplier

This block multiplies two binary polynomials, each of degree below `N` with coefficients in GF(2), and returns the full unreduced product of degree below `2N-1`. It is meant to sit in the field-arithmetic path of an elliptic-curve engine. Modular reduction is done elsewhere.

Each operand is cut into an upper half and a lower half of `N/2` bits. The block has one combinational carry-less multiplier of half width, and it uses that multiplier in three consecutive cycles. In the first cycle it forms the product of the two lower halves. In the second it forms the product of the two upper halves. In the third it forms the product of the two half-sums, each half-sum being the XOR of an operand's upper and lower half. In each cycle the new partial product is XOR-ed into the result register at the right offsets, so no partial product is kept after its cycle.

A one-cycle `start` pulse is accepted only while the block is idle. The operands are captured at that moment. The `done` flag pulses when the product is ready, and the product stays on the output until the next start is accepted.

Top module: `kara_mult`

## Requirements
- R1: When `done` is high, `product` equals the carry-less (XOR-accumulated) product of the `opA` and `opB` values captured at the accepted start. Bit i of each operand is the coefficient of x^i, and bit k of `product` is the coefficient of x^k.
- R2: The shared half multiplier is used in exactly three cycles per operation, in a fixed order: low halves, then high halves, then half-sums. At most one of these three selections is active in any cycle.
- R3: A start is accepted when `start` is high at a rising edge while the block is idle. `done` is then high during the fourth cycle after the cycle in which `start` was sampled.
- R4: `done` is high for exactly one cycle per accepted operation.
- R5: A `start` pulse that arrives while an operation is in progress is ignored. Its operands do not affect the running result, and `done` keeps its original timing.
- R6: The operands are latched on acceptance. Changes on `opA`/`opB` after that edge do not affect the result.
- R7: `product` keeps its value after `done` until the next start is accepted.
- R8: A synchronous active-high `rst` clears `product` to zero, drives `done` low and returns the block to idle, including when an operation is in progress. After reset, `done` stays low until a new start is accepted.
- R9: A zero operand gives a zero product. All-ones operands give the carry-less square of the all-ones polynomial.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a multiplication; honoured only when idle |
| opA | input | N | First operand polynomial, bit i = coefficient of x^i |
| opB | input | N | Second operand polynomial, bit i = coefficient of x^i |
| product | output | 2N-1 | Unreduced product polynomial |
| done | output | 1 | One-cycle pulse: product is valid |

## Verification
Two events can land in the same cycle: a new `start` arriving while the shared multiplier is still working on an earlier pair, and the operand inputs changing just after they were captured. The bench drives a second start with different operands in the middle of an operation and scrambles `opA`/`opB` right after acceptance. It then judges the outcome by checking that `done` still appears in its expected cycle and that the product matches the first operand pair. A bit-serial shift-and-XOR model computes the expected products for random operands and for the zero and all-ones corners.

// File: rtl/kmul_pkg.sv
package kmul_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;    // capture operands, clear accumulator
    logic selLo;   // low halves through the multiplier
    logic selHi;   // high halves through the multiplier
    logic selMid;  // half-sums through the multiplier
  } kmulCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_MID  = 2'd3
  } kmulState_t;

endpackage

// File: rtl/kmul_clmul.sv
module kmul_clmul #(
  parameter int W = 8
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-2:0] z
);
  localparam int RW = 2 * W - 1;

  logic [RW-1:0] rows [W];

  // One shifted copy of x per set bit of y
  for (genvar g = 0; g < W; g++) begin : g_row
    assign rows[g] = y[g] ? (RW'(x) << g) : '0;
  end

  always_comb begin
    z = '0;
    for (int i = 0; i < W; i++) z = z ^ rows[i];
  end
endmodule

// File: rtl/kmul_ctrl.sv
module kmul_ctrl
  import kmul_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  output kmulCtrl_t strb,
  output logic      done
);
  kmulState_t state, stateNext;

  always_comb begin
    strb.load   = start && (state == ST_IDLE);
    strb.selLo  = (state == ST_LO);
    strb.selHi  = (state == ST_HI);
    strb.selMid = (state == ST_MID);
  end

  always_comb begin
    unique case (state)
      ST_IDLE: stateNext = start ? ST_LO : ST_IDLE;
      ST_LO:   stateNext = ST_HI;
      ST_HI:   stateNext = ST_MID;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == ST_MID);
    end
  end

  // R2: one multiplier selection at a time, in the order lo, hi, mid
  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.selLo, strb.selHi, strb.selMid}));
  p_lo_then_hi_r2: assert property (@(posedge clk) disable iff (rst)
    strb.selLo |=> strb.selHi);
  p_hi_then_mid_r2: assert property (@(posedge clk) disable iff (rst)
    strb.selHi |=> strb.selMid);

  // R3: done follows an accepted start after a fixed latency
  p_done_latency_r3: assert property (@(posedge clk) disable iff (rst)
    strb.load |-> ##4 done);

  // R4: done is a single-cycle pulse
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/kmul_dp.sv
module kmul_dp
  import kmul_pkg::*;
#(
  parameter int N = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  kmulCtrl_t     strb,
  input  logic [N-1:0]  opA,
  input  logic [N-1:0]  opB,
  output logic [2*N-2:0] acc
);
  localparam int HW  = N / 2;
  localparam int HPW = 2 * HW - 1;
  localparam int PW  = 2 * N - 1;

  logic [N-1:0]   opAReg, opBReg;
  logic [HW-1:0]  mulX, mulY;
  logic [HPW-1:0] part;
  logic [PW-1:0]  partExt, addend;

  wire [HW-1:0] aLo = opAReg[HW-1:0];
  wire [HW-1:0] aHi = opAReg[N-1:HW];
  wire [HW-1:0] bLo = opBReg[HW-1:0];
  wire [HW-1:0] bHi = opBReg[N-1:HW];

  always_comb begin
    if (strb.selLo) begin
      mulX = aLo;
      mulY = bLo;
    end else if (strb.selHi) begin
      mulX = aHi;
      mulY = bHi;
    end else begin
      mulX = aHi ^ aLo;
      mulY = bHi ^ bLo;
    end
  end

  kmul_clmul #(.W(HW)) u_half (
    .x(mulX),
    .y(mulY),
    .z(part)
  );

  // Place each partial product at its Karatsuba offsets in one XOR step
  always_comb begin
    partExt = PW'(part);
    addend  = '0;
    if (strb.selLo)  addend = partExt ^ (partExt << HW);
    if (strb.selHi)  addend = (partExt << N) ^ (partExt << HW);
    if (strb.selMid) addend = partExt << HW;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opAReg <= '0;
      opBReg <= '0;
      acc    <= '0;
    end else if (strb.load) begin
      opAReg <= opA;
      opBReg <= opB;
      acc    <= '0;
    end else if (strb.selLo || strb.selHi || strb.selMid) begin
      acc <= acc ^ addend;
    end
  end

  // R7: the result register only moves on load or a multiplier step
  p_hold_result_r7: assert property (@(posedge clk) disable iff (rst)
    !(strb.load || strb.selLo || strb.selHi || strb.selMid) |=> $stable(acc));

  // R6: captured operands stay fixed while the multiplier is in use
  p_operands_held_r6: assert property (@(posedge clk) disable iff (rst)
    (strb.selLo || strb.selHi) |=> $stable(opAReg) && $stable(opBReg));
endmodule

// File: rtl/kara_mult.sv
module kara_mult
  import kmul_pkg::*;
#(
  parameter int N = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [N-1:0]   opA,
  input  logic [N-1:0]   opB,
  output logic [2*N-2:0] product,
  output logic           done
);
  if (N % 2 != 0) begin : g_width_check
    $error("kara_mult: N must be even");
  end

  kmulCtrl_t strb;

  kmul_ctrl u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .strb (strb),
    .done (done)
  );

  kmul_dp #(.N(N)) u_dp (
    .clk (clk),
    .rst (rst),
    .strb(strb),
    .opA (opA),
    .opB (opB),
    .acc (product)
  );
endmodule

// File: tb/sim_kara_mult.sv
`timescale 1ns/1ps
module sim_kara_mult;
  localparam int N  = 16;
  localparam int PW = 2 * N - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [N-1:0]  opA = '0;
  logic [N-1:0]  opB = '0;
  logic [PW-1:0] product;
  logic          done;

  int testsRun = 0;
  int testsFailed = 0;

  always #4 clk = ~clk;

  kara_mult #(.N(N)) u0 (
    .clk(clk), .rst(rst), .start(start),
    .opA(opA), .opB(opB), .product(product), .done(done)
  );

  function automatic logic [PW-1:0] refMul(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [PW-1:0] r;
    logic [PW-1:0] sh;
    r  = '0;
    sh = PW'(a);
    for (int i = 0; i < N; i++) begin
      if (b[i]) r = r ^ sh;
      sh = sh << 1;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Full operation. midStart injects a busy start (R5); operands scrambled after acceptance (R6).
  task automatic runOp(input logic [N-1:0] a, input logic [N-1:0] b, input bit midStart, input string tag);
    logic [PW-1:0] exp;
    exp = refMul(a, b);
    opA = a; opB = b; start = 1'b1;
    @(negedge clk);                      // after accepting edge
    start = 1'b0; opA = ~a; opB = b ^ 16'h5a3c;
    check(done == 1'b0, {tag, " R3 early"}, 64'(done), 64'd0);
    @(negedge clk);                      // first step done
    if (midStart) begin opA = 16'hffff; opB = 16'h1234; start = 1'b1; end
    check(done == 1'b0, {tag, " R3 early"}, 64'(done), 64'd0);
    @(negedge clk);                      // second step done
    start = 1'b0;
    check(done == 1'b0, {tag, " R3 early"}, 64'(done), 64'd0);
    @(negedge clk);                      // third step done: result valid
    check(done == 1'b1, {tag, " R3 done"}, 64'(done), 64'd1);
    check(product == exp, {tag, " R1 product"}, 64'(product), 64'(exp));
    @(negedge clk);
    check(done == 1'b0, {tag, " R4 pulse"}, 64'(done), 64'd0);
    check(product == exp, {tag, " R7 hold"}, 64'(product), 64'(exp));
  endtask

  initial begin : watchdog
    #(200000 * 8);
    testsFailed++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    check(product == '0, "R8 reset product", 64'(product), 64'd0);
    check(done == 1'b0, "R8 reset done", 64'(done), 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // R9 corner cases
    runOp(16'h0000, 16'hbeef, 1'b0, "R9 zeroA");
    runOp(16'hc0de, 16'h0000, 1'b0, "R9 zeroB");
    runOp(16'hffff, 16'hffff, 1'b0, "R9 ones");
    runOp(16'h0001, 16'h8000, 1'b0, "R1 single");
    runOp(16'h00ff, 16'hff00, 1'b0, "R1 halves");

    // R5 / R6: busy start with different operands must be ignored
    runOp(16'h1357, 16'h2468, 1'b1, "R5 busy");
    runOp(16'h8001, 16'h7ffe, 1'b1, "R5 busy2");

    // Back-to-back starts straight after done
    runOp(16'ha5a5, 16'h5a5a, 1'b0, "R6 b2b1");
    runOp(16'h0f0f, 16'hf0f0, 1'b0, "R6 b2b2");

    // R7: idle gap keeps product
    begin
      logic [PW-1:0] held;
      held = refMul(16'h0f0f, 16'hf0f0);
      opA = 16'h1111; opB = 16'h2222;
      repeat (5) @(negedge clk);
      check(product == held, "R7 idle hold", 64'(product), 64'(held));
    end

    // Random operands
    for (int k = 0; k < 200; k++) begin
      runOp(16'($urandom), 16'($urandom), k[2], "R1 random");
    end

    // R8: reset in the middle of an operation
    opA = 16'hdead; opB = 16'hbeef; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(product == '0, "R8 midop product", 64'(product), 64'd0);
    check(done == 1'b0, "R8 midop done", 64'(done), 64'd0);
    rst = 1'b0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check(done == 1'b0, "R8 idle after reset", 64'(done), 64'd0);
    end
    runOp(16'h4321, 16'h8765, 1'b0, "R8 after reset");

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule